// File: doc/BRIEF.md
# Pseudo-Random Self-Test Engine

This block runs a complete built-in self-test pass on a small combinational circuit. A 4-bit feedback shift register produces a repeatable pseudo-random stream of test vectors on `vec_o`. The circuit under test sits outside the engine: its inputs come from `vec_o`, and its outputs return on `resp_i`. A second shift register of the same kind folds each response into a running signature. Each response is XORed into its stages.

One `start` pulse carries the whole pass. It loads the seed, clears the signature and applies the programmed number of vectors. At the end it compares the final signature with the expected value supplied on `exp_i`. A one-cycle `done_o` marks the end of the pass, and `pass_o` reports the comparison. Because the same seed always gives the same vector stream, the expected signature can be worked out in advance.

Top module: `bist_engine`

## Requirements
- R1: While a pass runs, the vector advances once per clock. The new top bit is x3 XOR x0, and every other bit moves one place toward bit 0, so 1000 is followed by 1100, 1110, 1111 and 0111 (bits shown x3..x0). When no pass is running, the vector holds its value.
- R2: Starting from any nonzero seed, the vector stream visits 15 distinct nonzero states and returns to the seed after exactly 15 steps.
- R3: A seed of 0000 is replaced by 1000 when it is loaded, so `vec_o` is never zero. The reset value of `vec_o` is 1000.
- R4: On the clock edge that accepts a start, the vector register loads the seed. `vec_o` equals the seed, after any R3 substitution, in the following cycle.
- R5: The signature register is cleared when a start is accepted. On each of the N vector cycles it takes the value {s3^s0, s3, s2, s1} XOR `resp_i`, where bit 3 is the leftmost position.
- R6: With a programmed count N ≥ 1, exactly N vectors are applied. `done_o` is high for exactly one cycle: the cycle that follows the N-th vector edge after the start edge.
- R7: `pass_o` is set with `done_o` when the final signature equals `exp_i`, and is otherwise low. It holds until the next accepted start and is low while a pass runs.
- R8: A start pulse that arrives while a pass is running is ignored. The vector stream, the count and the result are unchanged.
- R9: With N = 0, `done_o` is high in the cycle after the start edge, no vector is applied, and `pass_o` is set when `exp_i` is zero (the cleared signature).
- R10: After reset `done_o` and `pass_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begins a self-test pass when no pass is running |
| seed_i | input | W (4) | Initial vector; zero is replaced by 1000 |
| len_i | input | CW (16) | Number of vectors to apply in the pass |
| vec_o | output | W (4) | Test vector driven into the circuit under test |
| resp_i | input | W (4) | Response from the circuit under test |
| exp_i | input | W (4) | Expected final signature, held stable during the pass |
| done_o | output | 1 | One-cycle pulse at the end of a pass |
| pass_o | output | 1 | Final signature matched `exp_i`; held until the next start |

## Verification
Some checks are made on every cycle by assertions:
- the vector is never zero, and holds while no pass runs;
- a load applies the seed, with the zero substitution;
- the signature is empty after a clear;
- the count stays below the programmed length;
- `pass_o` is low during a pass, and `done_o` never lasts two cycles.

Other behaviour only the bench scenarios can show. These are the exact feedback sequence, the 15-state period, the signature value after many folded responses, and the count-to-done timing. They also include the N = 0 corner and the effect of a start that arrives in the middle of a pass. The bench compares these against a software model of both shift registers and of a fixed test circuit.

// File: rtl/bist_pkg.sv
package bist_pkg;
   localparam int unsigned BIST_W    = 4;
   localparam int unsigned BIST_CW   = 16;
   localparam logic [3:0]  BIST_TAPS = 4'b1001;

   typedef enum logic [0:0] {
      SEQ_IDLE = 1'b0,
      SEQ_RUN  = 1'b1
   } seq_state_e;
endpackage

// File: rtl/bist_pattern_gen.sv
module bist_pattern_gen #(
   parameter int unsigned W    = 4,
   parameter logic [W-1:0] TAPS = 4'b1001
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] seed_i,
   input  logic         adv_i,
   output logic [W-1:0] vec_o
);
   localparam logic [W-1:0] TOP_ONE = {1'b1, {(W-1){1'b0}}};

   generate
      if (W < 2) begin : g_bad_w
         $error("bist_pattern_gen: W must be at least 2");
      end
      if (TAPS[0] != 1'b1) begin : g_bad_taps
         $error("bist_pattern_gen: TAPS must include bit 0");
      end
   endgenerate

   logic [W-1:0] state_q;
   logic [W-1:0] seed_fix;
   logic         fb;

   assign seed_fix = (seed_i == '0) ? TOP_ONE : seed_i;
   assign fb       = ^(state_q & TAPS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      state_q <= TOP_ONE;
      else if (load_i) state_q <= seed_fix;
      else if (adv_i)  state_q <= {fb, state_q[W-1:1]};
   end

   assign vec_o = state_q;

   // R3: the register is never locked at zero
   p_never_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      state_q != '0);

   // R1: an idle generator holds its vector
   p_hold_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !adv_i) |=> $stable(state_q));

   // R4: a load applies the seed, zero replaced
   p_load_seed_r4: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (state_q == (($past(seed_i) == '0) ? TOP_ONE : $past(seed_i))));
endmodule

// File: rtl/bist_sig_comp.sv
module bist_sig_comp #(
   parameter int unsigned W    = 4,
   parameter logic [W-1:0] TAPS = 4'b1001
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         fold_i,
   input  logic [W-1:0] resp_i,
   output logic [W-1:0] sig_nxt_o
);
   logic [W-1:0] sig_q;
   logic [W-1:0] nxt;
   logic         fb;

   assign fb = ^(sig_q & TAPS);

   genvar gi;
   generate
      for (gi = 0; gi < W; gi++) begin : g_stage
         if (gi == W - 1) begin : g_top
            assign nxt[gi] = fb ^ resp_i[gi];
         end else begin : g_mid
            assign nxt[gi] = sig_q[gi+1] ^ resp_i[gi];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sig_q <= '0;
      else if (clr_i)  sig_q <= '0;
      else if (fold_i) sig_q <= nxt;
   end

   assign sig_nxt_o = nxt;

   // R5: a clear empties the signature
   p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (sig_q == '0));

   // R5: without a fold or clear the signature holds
   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && !fold_i) |=> $stable(sig_q));
endmodule

// File: rtl/bist_seq.sv
module bist_seq
   import bist_pkg::*;
#(
   parameter int unsigned CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [CW-1:0] len_i,
   input  logic          match_i,
   input  logic          zero_ok_i,
   output logic          load_o,
   output logic          run_o,
   output logic          done_o,
   output logic          pass_o
);
   generate
      if (CW < 1) begin : g_bad_cw
         $error("bist_seq: CW must be at least 1");
      end
   endgenerate

   seq_state_e    st_q;
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] len_q;
   logic          done_q;
   logic          pass_q;

   assign load_o = start_i && (st_q == SEQ_IDLE);
   assign run_o  = (st_q == SEQ_RUN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= SEQ_IDLE;
         cnt_q  <= '0;
         len_q  <= '0;
         done_q <= 1'b0;
         pass_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (load_o) begin
            cnt_q  <= '0;
            len_q  <= len_i;
            pass_q <= 1'b0;
            if (len_i == '0) begin
               done_q <= 1'b1;
               pass_q <= zero_ok_i;
            end else begin
               st_q <= SEQ_RUN;
            end
         end else if (st_q == SEQ_RUN) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == len_q - 1'b1) begin
               st_q   <= SEQ_IDLE;
               done_q <= 1'b1;
               pass_q <= match_i;
            end
         end
      end
   end

   assign done_o = done_q;
   assign pass_o = pass_q;

   // R6: done is a single-cycle pulse
   p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !start_i) |=> !done_q);

   // R6: the count never reaches the programmed length while running
   p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SEQ_RUN) |-> (cnt_q < len_q));

   // R7: no pass indication while a pass is in progress
   p_pass_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SEQ_RUN) |-> !pass_q);
endmodule

// File: rtl/bist_engine.sv
module bist_engine
   import bist_pkg::*;
#(
   parameter int unsigned  W    = BIST_W,
   parameter int unsigned  CW   = BIST_CW,
   parameter logic [W-1:0] TAPS = BIST_TAPS
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [W-1:0]  seed_i,
   input  logic [CW-1:0] len_i,
   output logic [W-1:0]  vec_o,
   input  logic [W-1:0]  resp_i,
   input  logic [W-1:0]  exp_i,
   output logic          done_o,
   output logic          pass_o
);
   logic         load;
   logic         run;
   logic [W-1:0] sig_nxt;
   logic         match;
   logic         zero_ok;

   assign match   = (sig_nxt == exp_i);
   assign zero_ok = (exp_i == '0);

   bist_seq #(.CW(CW)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .len_i     (len_i),
      .match_i   (match),
      .zero_ok_i (zero_ok),
      .load_o    (load),
      .run_o     (run),
      .done_o    (done_o),
      .pass_o    (pass_o)
   );

   bist_pattern_gen #(.W(W), .TAPS(TAPS)) u_gen (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load),
      .seed_i (seed_i),
      .adv_i  (run),
      .vec_o  (vec_o)
   );

   bist_sig_comp #(.W(W), .TAPS(TAPS)) u_comp (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (load),
      .fold_i    (run),
      .resp_i    (resp_i),
      .sig_nxt_o (sig_nxt)
   );

   // R10: reset leaves no result behind
   p_reset_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!done_o && !pass_o));
endmodule

// File: tb/sim_bist_engine.sv
module sim_bist_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [3:0]  seed = 4'd0;
   logic [15:0] len = 16'd0;
   logic [3:0]  vec;
   logic [3:0]  resp;
   logic [3:0]  expv = 4'd0;
   logic        done;
   logic        pass;
   int          checks = 0;
   int          errors = 0;

   always #2 clk = ~clk;

   function automatic logic [3:0] cut_f(input logic [3:0] v);
      return {v[3] ^ v[1], v[2] & v[0], v[1] | v[3], ~v[0]};
   endfunction

   function automatic logic [3:0] gen_step(input logic [3:0] v);
      return {v[3] ^ v[0], v[3:1]};
   endfunction

   function automatic logic [3:0] comp_step(input logic [3:0] s, input logic [3:0] r);
      return {s[3] ^ s[0], s[3:1]} ^ r;
   endfunction

   function automatic logic [3:0] fix_seed(input logic [3:0] s);
      return (s == 4'd0) ? 4'b1000 : s;
   endfunction

   assign resp = cut_f(vec);

   bist_engine u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start), .seed_i(seed), .len_i(len),
      .vec_o(vec), .resp_i(resp), .exp_i(expv), .done_o(done), .pass_o(pass)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp_val);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_val);
      end
   endtask

   // One pass; mid_start injects an extra start at step 3 (R8)
   task automatic run_pass(input logic [3:0] sd, input int n, input bit want_pass,
                           input bit mid_start);
      logic [3:0] v;
      logic [3:0] s;
      logic [3:0] e;
      v = fix_seed(sd);
      s = 4'd0;
      for (int k = 0; k < n; k++) begin
         s = comp_step(s, cut_f(v));
         v = gen_step(v);
      end
      e = want_pass ? s : (s ^ 4'(1 + ($urandom % 15)));
      @(negedge clk);
      seed = sd; len = 16'(n); expv = e; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(vec == fix_seed(sd), "R4/R3 seed load", vec, fix_seed(sd));
      if (n == 0) begin
         chk(done == 1'b1, "R9 done at zero count", done, 1);
         chk(pass == want_pass, "R9 pass at zero count", pass, want_pass);
      end else begin
         chk(pass == 1'b0, "R7 pass low while running", pass, 0);
         v = fix_seed(sd);
         for (int i = 1; i <= n; i++) begin
            if (mid_start && i == 3) begin
               seed = ~sd; len = 16'd1; start = 1'b1;
            end
            @(negedge clk);
            if (mid_start && i == 3) begin
               start = 1'b0; seed = sd; len = 16'(n);
            end
            v = gen_step(v);
            chk(vec == v, "R1 vector step", vec, v);
            if (i < n) chk(done == 1'b0, mid_start ? "R8 ignored start" : "R6 early done",
                           done, 0);
         end
         chk(done == 1'b1, "R6 done after N vectors", done, 1);
         chk(pass == want_pass, "R5/R7 signature compare", pass, want_pass);
      end
      @(negedge clk);
      chk(done == 1'b0, "R6 single-cycle done", done, 0);
      chk(pass == want_pass, "R7 pass held", pass, want_pass);
      chk(vec == v, "R1 vector holds when idle", vec, v);
   endtask

   initial begin
      int unsigned r;
      r = $urandom(32'h5eed);
      repeat (3) @(negedge clk);
      chk(done == 1'b0, "R10 done after reset", done, 0);
      chk(pass == 1'b0, "R10 pass after reset", pass, 0);
      chk(vec == 4'b1000, "R3 reset vector", vec, 4'b1000);
      rst_n = 1'b1;
      // R1: exact sequence from 1000
      @(negedge clk);
      seed = 4'b1000; len = 16'd4; start = 1'b1;
      @(negedge clk); start = 1'b0;
      @(negedge clk); chk(vec == 4'b1100, "R1 step 1", vec, 4'b1100);
      @(negedge clk); chk(vec == 4'b1110, "R1 step 2", vec, 4'b1110);
      @(negedge clk); chk(vec == 4'b1111, "R1 step 3", vec, 4'b1111);
      @(negedge clk); chk(vec == 4'b0111, "R1 step 4", vec, 4'b0111);
      // R2: period of 15
      run_pass(4'b1000, 15, 1'b1, 1'b0);
      chk(vec == 4'b1000, "R2 period 15", vec, 4'b1000);
      run_pass(4'b0110, 15, 1'b1, 1'b0);
      chk(vec == 4'b0110, "R2 period 15 other seed", vec, 4'b0110);
      // R3: zero seed
      run_pass(4'b0000, 5, 1'b1, 1'b0);
      // R9: zero count
      run_pass(4'b0101, 0, 1'b0, 1'b0);
      @(negedge clk);
      seed = 4'b0011; len = 16'd0; expv = 4'd0; start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk(done == 1'b1 && pass == 1'b1, "R9 zero count with zero expected", pass, 1);
      // R8: start while running
      run_pass(4'b1010, 12, 1'b1, 1'b1);
      // R5/R7: random passes and mismatches
      for (int t = 0; t < 40; t++) begin
         run_pass(4'($urandom), 1 + ($urandom % 40), 1'($urandom), 1'b0);
      end
      // R1: single-vector pass
      run_pass(4'b1111, 1, 1'b1, 1'b0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule